// File: doc/BRIEF.md
# Packed SIMD Add/Subtract Unit

This block is a 32-bit packed-arithmetic execution unit. It treats each operand either as four independent byte lanes or as two independent halfword lanes, and it adds, subtracts or applies a crossed add/subtract to every lane at once. Each operation has a signed or unsigned form, and each form either wraps or saturates. No carry ever passes from one lane to the next.

Beside the lane results, the unit keeps a four-bit greater-or-equal flag vector with one bit per byte lane. The wrapping operations write this vector, and a byte-select operation reads it, so a subtract followed by a select builds a lane-wise maximum or minimum. The caller supplies an opcode, two operands and a valid strobe. The result, the flags and a valid bit appear one clock later.

Top module: `pack_simd_alu`

## Requirements
- R1: The opcode is 5 bits. Bits [4:2] give the function: 0 byte add, 1 byte subtract, 2 halfword add, 3 halfword subtract, 4 crossed add-high/subtract-low, 5 crossed subtract-high/add-low, 6 and 7 byte select. Bits [1:0] give the kind: 0 signed wrap, 1 unsigned wrap, 2 signed saturate, 3 unsigned saturate. `out_valid` is high exactly one cycle after `in_valid`. A cycle with `in_valid` low leaves `result` and `ge_flags` unchanged.
- R2: The byte functions work on four 8-bit lanes, bits [8i+7:8i]. In the wrap kinds each result byte is the low 8 bits of the lane sum or difference, and no carry passes between lanes.
- R3: The halfword functions work on two 16-bit lanes, bits [15:0] and [31:16], with 16-bit wraparound in the wrap kinds.
- R4: Function 4 first swaps the two halfwords of `opb`. The upper result lane is opa[31:16] + opb[15:0], and the lower result lane is opa[15:0] - opb[31:16].
- R5: Function 5 uses the same swap. The upper result lane is opa[31:16] - opb[15:0], and the lower result lane is opa[15:0] + opb[31:16].
- R6: In the signed-saturate kind, each lane result is clamped to the lane's signed range: 0x7F/0x80 for bytes, 0x7FFF/0x8000 for halfwords.
- R7: In the unsigned-saturate kind, an add that overflows gives all ones, and a subtract that would go below zero gives 0.
- R8: In the unsigned-wrap kind, a lane flag is set when an add carries out of the lane, or when a subtract does not borrow.
- R9: In the signed-wrap kind, a lane flag is set when the exact 9-bit (byte) or 17-bit (halfword) result is zero or positive.
- R10: A halfword lane writes its flag into both flag bits of the bytes it covers: bits 1:0 for the low halfword and bits 3:2 for the high halfword.
- R11: The saturating kinds and the select function leave `ge_flags` unchanged.
- R12: Select builds result byte i from opa when ge_flags[i] is 1, and from opb when it is 0. It uses the flags held before the operation.
- R13: After a synchronous reset, `out_valid`, `result` and `ge_flags` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 5 | Function [4:2] and kind [1:0] |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 32 | Registered lane results |
| ge_flags | output | 4 | Registered per-byte greater-or-equal flags |

## Verification
Every one of the 32 opcodes is driven with operands built from the lane boundary bytes 0x00, 0x7F, 0x80 and 0xFF, and then with random words. Each result is compared against an integer model of exact lane arithmetic. The boundary bytes separate signed from unsigned overflow and separate a clamp from a wrap. Random words with mixed lanes expose any carry that leaks between lanes and any halfword swap that goes to the wrong lane. Subtracts followed by selects show that the flags are written and read in the correct order. Saturating operations placed between them show that the flags are held, and idle cycles show that nothing is updated without the strobe.

// File: rtl/pack_simd_pkg.sv
package pack_simd_pkg;
  localparam int OP_W   = 5;
  localparam int FUNC_W = 3;
  localparam int KIND_W = 2;

  typedef enum logic [FUNC_W-1:0] {
    FN_ADD8  = 3'd0,
    FN_SUB8  = 3'd1,
    FN_ADD16 = 3'd2,
    FN_SUB16 = 3'd3,
    FN_AHSL  = 3'd4,
    FN_SHAL  = 3'd5,
    FN_SEL   = 3'd6,
    FN_SELB  = 3'd7
  } func_e;

  // kind[0] = unsigned, kind[1] = saturate
  typedef logic [KIND_W-1:0] kind_t;
endpackage

// File: rtl/simd_lane.sv
module simd_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         sgn,
  input  logic         sat,
  output logic [W-1:0] res,
  output logic         ge
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0] ea, eb, full;
  logic       s_ovf;

  always_comb begin
    ea   = {sgn & a[W-1], a};
    eb   = {sgn & b[W-1], b};
    full = sub ? (ea - eb) : (ea + eb);
    s_ovf = full[W] ^ full[W-1];
    // signed: non-negative exact result; unsigned add: carry; unsigned sub: no borrow
    if (sgn || sub) ge = ~full[W];
    else            ge = full[W];
    res = full[W-1:0];
    if (sat) begin
      if (sgn) begin
        if (s_ovf) res = full[W] ? SMIN : SMAX;
      end else if (full[W]) begin
        res = sub ? '0 : '1;
      end
    end
  end
endmodule

// File: rtl/simd_bytesel.sv
module simd_bytesel #(
  parameter int LANES = 4,
  parameter int BW    = 8
) (
  input  logic [LANES*BW-1:0] a,
  input  logic [LANES*BW-1:0] b,
  input  logic [LANES-1:0]    pick_a,
  output logic [LANES*BW-1:0] y
);
  for (genvar i = 0; i < LANES; i++) begin : g_sel
    assign y[i*BW +: BW] = pick_a[i] ? a[i*BW +: BW] : b[i*BW +: BW];
  end
endmodule

// File: rtl/pack_simd_alu.sv
module pack_simd_alu
  import pack_simd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W/BYTE_W-1:0] ge_flags
);
  localparam int NB     = DATA_W / BYTE_W;
  localparam int HALF_W = 2 * BYTE_W;
  localparam int NH     = DATA_W / HALF_W;
  localparam int BPH    = HALF_W / BYTE_W;

  func_e       fn;
  kind_t       kind;
  logic        sgn, sat, swap;
  logic [DATA_W-1:0] b_res, h_res, s_res, nxt_res;
  logic [NB-1:0]     b_ge, h_ge_wide, nxt_ge;
  logic [NH-1:0]     h_ge;
  logic              ge_we;

  assign fn   = func_e'(op[OP_W-1:KIND_W]);
  assign kind = op[KIND_W-1:0];
  assign sgn  = ~kind[0];
  assign sat  = kind[1];
  assign swap = (fn == FN_AHSL) || (fn == FN_SHAL);

  for (genvar i = 0; i < NB; i++) begin : g_byte
    simd_lane #(.W(BYTE_W)) u_lane (
      .a   (opa[i*BYTE_W +: BYTE_W]),
      .b   (opb[i*BYTE_W +: BYTE_W]),
      .sub (fn == FN_SUB8),
      .sgn (sgn),
      .sat (sat),
      .res (b_res[i*BYTE_W +: BYTE_W]),
      .ge  (b_ge[i])
    );
  end

  for (genvar h = 0; h < NH; h++) begin : g_half
    logic [HALF_W-1:0] hb;
    logic              hsub;
    assign hb   = swap ? opb[(NH-1-h)*HALF_W +: HALF_W] : opb[h*HALF_W +: HALF_W];
    assign hsub = (fn == FN_SUB16) ||
                  ((fn == FN_AHSL) && (h == 0)) ||
                  ((fn == FN_SHAL) && (h != 0));
    simd_lane #(.W(HALF_W)) u_lane (
      .a   (opa[h*HALF_W +: HALF_W]),
      .b   (hb),
      .sub (hsub),
      .sgn (sgn),
      .sat (sat),
      .res (h_res[h*HALF_W +: HALF_W]),
      .ge  (h_ge[h])
    );
    assign h_ge_wide[h*BPH +: BPH] = {BPH{h_ge[h]}};
  end

  simd_bytesel #(.LANES(NB), .BW(BYTE_W)) u_sel (
    .a      (opa),
    .b      (opb),
    .pick_a (ge_flags),
    .y      (s_res)
  );

  always_comb begin
    nxt_res = s_res;
    nxt_ge  = b_ge;
    ge_we   = 1'b0;
    unique case (fn)
      FN_ADD8, FN_SUB8: begin
        nxt_res = b_res;
        nxt_ge  = b_ge;
        ge_we   = ~sat;
      end
      FN_ADD16, FN_SUB16, FN_AHSL, FN_SHAL: begin
        nxt_res = h_res;
        nxt_ge  = h_ge_wide;
        ge_we   = ~sat;
      end
      default: begin
        nxt_res = s_res;
        ge_we   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      ge_flags  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= nxt_res;
        if (ge_we) ge_flags <= nxt_ge;
      end
    end
  end
endmodule

// File: rtl/pack_simd_alu_chk.sv
module pack_simd_alu_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [4:0]  op,
  input logic [31:0] opa,
  input logic [31:0] opb,
  input logic        out_valid,
  input logic [31:0] result,
  input logic [3:0]  ge_flags
);
  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(ge_flags)));

  // R11
  flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op[1] || op[4:3] == 2'b11)) |=> $stable(ge_flags));

  // R10
  half_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op[1] && op[4:2] >= 3'd2 && op[4:2] <= 3'd5) |=>
      (ge_flags[1] == ge_flags[0] && ge_flags[3] == ge_flags[2]));

  // R12
  sel_low_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op[4:3] == 2'b11) |=>
      result[7:0] == ($past(ge_flags[0]) ? $past(opa[7:0]) : $past(opb[7:0])));

  // R12
  sel_high_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op[4:3] == 2'b11) |=>
      result[31:24] == ($past(ge_flags[3]) ? $past(opa[31:24]) : $past(opb[31:24])));

  // R2
  uadd8_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 5'b00001) |=>
      result[15:8] == 8'($past(opa[15:8]) + $past(opb[15:8])));
endmodule

bind pack_simd_alu pack_simd_alu_chk u_chk (.*);

// File: tb/pack_simd_alu_test.sv
`timescale 1ns/1ps
module pack_simd_alu_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [4:0]  op;
  logic [31:0] opa, opb;
  logic        out_valid;
  logic [31:0] result;
  logic [3:0]  ge_flags;

  int total = 0;
  int bad   = 0;
  logic [3:0] ge_m;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pack_simd_alu uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .opa(opa), .opb(opb), .out_valid(out_valid),
    .result(result), .ge_flags(ge_flags)
  );

  task automatic chk32(input string rq, input logic [31:0] act, exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp_v);
    end
  endtask

  // returns {ge, res[15:0]} from exact integer arithmetic
  function automatic logic [16:0] lane_ref(input int w, input logic [15:0] x, y,
                                           input bit sub, sgn, sat);
    longint ix, iy, r, lo, hi, m;
    bit g;
    m  = (64'sd1 <<< w) - 1;
    ix = longint'(x) & m;
    iy = longint'(y) & m;
    if (sgn && ix[w-1]) ix = ix - (64'sd1 <<< w);
    if (sgn && iy[w-1]) iy = iy - (64'sd1 <<< w);
    r  = sub ? ix - iy : ix + iy;
    lo = sgn ? -(64'sd1 <<< (w-1)) : 0;
    hi = sgn ? (64'sd1 <<< (w-1)) - 1 : m;
    if (sgn || sub) g = (r >= 0);
    else            g = (r > hi);
    if (sat) begin
      if (r > hi) r = hi;
      if (r < lo) r = lo;
    end
    r = r & m;
    return {g, r[15:0]};
  endfunction

  task automatic model(input logic [4:0] o, input logic [31:0] a, b,
                       output logic [31:0] r, output logic [3:0] g);
    int fn;
    bit sgn, sat;
    logic [3:0] gt;
    logic [31:0] bb;
    logic [16:0] lr;
    fn = int'(o[4:2]); sgn = !o[0]; sat = o[1];
    r = '0; gt = '0;
    if (fn >= 6) begin
      for (int i = 0; i < 4; i++) r[8*i +: 8] = ge_m[i] ? a[8*i +: 8] : b[8*i +: 8];
    end else if (fn < 2) begin
      for (int i = 0; i < 4; i++) begin
        lr = lane_ref(8, {8'h0, a[8*i +: 8]}, {8'h0, b[8*i +: 8]}, fn == 1, sgn, sat);
        r[8*i +: 8] = lr[7:0];
        gt[i] = lr[16];
      end
    end else begin
      bb = (fn >= 4) ? {b[15:0], b[31:16]} : b;
      for (int h = 0; h < 2; h++) begin
        lr = lane_ref(16, a[16*h +: 16], bb[16*h +: 16],
                      (fn == 3) || (fn == 4 && h == 0) || (fn == 5 && h == 1), sgn, sat);
        r[16*h +: 16] = lr[15:0];
        gt[2*h] = lr[16];
        gt[2*h+1] = lr[16];
      end
    end
    if (!sat && fn < 6) ge_m = gt;
    g = ge_m;
  endtask

  function automatic string res_req(input logic [4:0] o);
    if (o[4:3] == 2'b11) return "R12";
    if (o[1]) return o[0] ? "R7" : "R6";
    case (o[4:2])
      3'd0, 3'd1: return "R2";
      3'd2, 3'd3: return "R3";
      3'd4:       return "R4";
      default:    return "R5";
    endcase
  endfunction

  function automatic string ge_req(input logic [4:0] o);
    if (o[1] || o[4:3] == 2'b11) return "R11";
    if (o[4:2] >= 3'd2) return "R10";
    return o[0] ? "R8" : "R9";
  endfunction

  task automatic run_op(input logic [4:0] o, input logic [31:0] a, b);
    logic [31:0] er;
    logic [3:0]  eg;
    model(o, a, b, er, eg);
    @(negedge clk);
    in_valid = 1'b1; op = o; opa = a; opb = b;
    @(negedge clk);
    in_valid = 1'b0;
    chk32("R1", {31'b0, out_valid}, 32'd1);
    chk32(res_req(o), result, er);
    chk32(ge_req(o), {28'b0, ge_flags}, {28'b0, eg});
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b0; op = '0; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk32("R13", {31'b0, out_valid}, 32'd0);
    chk32("R13", result, 32'd0);
    chk32("R13", {28'b0, ge_flags}, 32'd0);
    ge_m = '0;
  endtask

  task automatic t_boundary;
    logic [7:0] bv [4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};
    for (int o = 0; o < 32; o++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          run_op(5'(o), {bv[i], bv[j], bv[(i+1)%4], bv[(j+3)%4]},
                        {bv[j], bv[i], bv[(j+2)%4], bv[(i+3)%4]});
  endtask

  task automatic t_random;
    for (int n = 0; n < 600; n++)
      run_op(5'($urandom_range(0, 31)), $urandom, $urandom);
  endtask

  task automatic t_directed;
    // R2 no carry between lanes: 0xFF+0x01 per byte
    run_op(5'b00001, 32'hFF01_FF01, 32'h0101_0101);
    // R4 swap: hi = 0x0010 + 0x0003, lo = 0x0008 - 0x0001
    run_op(5'b10001, 32'h0010_0008, 32'h0001_0003);
    // R5 swap
    run_op(5'b10101, 32'h0010_0008, 32'h0001_0003);
    // R6 signed clamp
    run_op(5'b00010, 32'h7F80_7F80, 32'h0101_0101);
    // R7 unsigned clamp low
    run_op(5'b00111, 32'h0000_0000, 32'h0001_0001);
  endtask

  task automatic t_flag_select;
    // R8 flags from unsigned subtract, then R11 sat op holds them, then R12 select
    run_op(5'b00101, 32'h1080_0540, 32'h2070_0640);
    run_op(5'b00011, 32'h1111_1111, 32'h2222_2222);
    run_op(5'b11000, 32'hAABB_CCDD, 32'h1122_3344);
    // R9 signed compare then select as max
    run_op(5'b00100, 32'h8001_7F00, 32'h7F00_8001);
    run_op(5'b11100, 32'h8001_7F00, 32'h7F00_8001);
  endtask

  task automatic t_idle;
    logic [31:0] r0;
    logic [3:0]  g0;
    r0 = result; g0 = ge_flags;
    @(negedge clk);
    op = 5'b00001; opa = 32'h1234_5678; opb = 32'h9ABC_DEF0; in_valid = 1'b0;
    @(negedge clk);
    chk32("R1", {31'b0, out_valid}, 32'd0);
    chk32("R1", result, r0);
    chk32("R1", {28'b0, ge_flags}, {28'b0, g0});
  endtask

  initial begin
    t_reset;
    t_directed;
    t_flag_select;
    t_idle;
    t_boundary;
    t_idle;
    t_random;
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule